// File: doc/BRIEF.md
# Product Accumulator With Dump Register

This block sums a stream of signed products, one product per clock, and hands each finished sum to a 16-bit output register. One accumulate control sets the phase. The sample that carries the control low starts a new window with its own product. Each later sample in that window carries the control high, and its product is added to the running sum. The next low sample ends the window: the output register takes the finished sum, and the running sum restarts from the new product.

The control and the product are both registered at the block's edge before they act. Any change on the inputs therefore reaches the sum and the output one clock after the edge that captures it. The internal sum is wide enough that a window of up to `MAX_RUN` full-scale products cannot wrap. The output is a 16-bit slice of the sum, and its lowest bit sits at the position `OUT_LSB`. By default that slice is the upper 16 bits.

Top module: `acc_dump`

## Requirements
- R1: While rst_ni is low, the output reads 0, and the running sum and registered control are cleared.
- R2: A sample presented with acc_i high adds its product to the running sum, and the output register keeps its value on that sample's effective edge.
- R3: A sample presented with acc_i low discards the previous sum; the new running sum equals its product alone.
- R4: A sample presented with acc_i low loads the output with bits [OUT_LSB+15:OUT_LSB] of the sum completed just before it (default OUT_LSB=16, i.e. sum bits [31:16]).
- R5: The input register captures acc_i and prod_i on a rising edge, and they act on the following rising edge. The output therefore changes on the second rising edge after the sample is presented, and not on the first.
- R6: prod_i is signed two's complement, and the sum has $clog2(MAX_RUN) guard bits. With the defaults, 256 products of -2^23 give an output of 0x8000, and 256 products of 2^23-1 give 0x7FFF.
- R7: Back-to-back low samples each form a one-product window, so every dump equals the single product presented two samples earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prod_i | input | PROD_W (24) | Signed product, one per clock |
| acc_i | input | 1 | High: add the product to the sum. Low: dump the sum and restart the window |
| sum_o | output | 16 | Output register: slice of the last completed sum |

## Verification
A product or control value presented before rising edge k is held in the input register after edge k. It changes the running sum at edge k+1, and a dump lands on sum_o at edge k+1 as well. The bench drives inputs and samples sum_o only on falling edges, and it tracks the expected window sums in its own model. After a closing sample it first checks that sum_o still holds the old value one edge later, then checks for the new dump one edge after that. Hold behaviour is checked on every falling edge inside a window, and single-sample windows are checked against the product presented two samples back.

// File: rtl/acc_dump_pkg.sv
package acc_dump_pkg;
  localparam int unsigned OUT_W = 16;

  typedef enum logic {
    PH_DUMP = 1'b0,
    PH_ACC  = 1'b1
  } acc_phase_e;
endpackage

// File: rtl/acc_in_reg.sv
module acc_in_reg #(
  parameter int unsigned PROD_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic                     acc_i,
  output logic signed [PROD_W-1:0] prod_q_o,
  output acc_dump_pkg::acc_phase_e phase_q_o
);
  import acc_dump_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q_o  <= '0;
      phase_q_o <= PH_DUMP;
    end else begin
      prod_q_o  <= prod_i;
      phase_q_o <= acc_i ? PH_ACC : PH_DUMP;
    end
  end
endmodule

// File: rtl/acc_sum.sv
module acc_sum #(
  parameter int unsigned PROD_W = 24,
  parameter int unsigned SUM_W  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [PROD_W-1:0] prod_q_i,
  input  acc_dump_pkg::acc_phase_e phase_q_i,
  output logic signed [SUM_W-1:0]  sum_q_o
);
  import acc_dump_pkg::*;

  localparam int unsigned EXT_W = SUM_W - PROD_W;

  logic signed [SUM_W-1:0] prod_ext;
  logic signed [SUM_W-1:0] sum_d;

  assign prod_ext = {{EXT_W{prod_q_i[PROD_W-1]}}, prod_q_i};

  always_comb begin
    unique case (phase_q_i)
      PH_ACC:  sum_d = sum_q_o + prod_ext;
      default: sum_d = prod_ext;  // restart the window
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q_o <= '0;
    else         sum_q_o <= sum_d;
  end
endmodule

// File: rtl/acc_dump_reg.sv
module acc_dump_reg #(
  parameter int unsigned SUM_W   = 32,
  parameter int unsigned OUT_LSB = 16
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic signed [SUM_W-1:0]                sum_q_i,
  input  acc_dump_pkg::acc_phase_e               phase_q_i,
  output logic        [acc_dump_pkg::OUT_W-1:0]  out_q_o
);
  import acc_dump_pkg::*;

  logic [OUT_W-1:0] slice;

  generate
    if (OUT_LSB + OUT_W <= SUM_W) begin : g_fit
      assign slice = sum_q_i[OUT_LSB +: OUT_W];
    end else begin : g_clip
      // parameter points past the top: keep the upper bits that exist
      assign slice = sum_q_i[SUM_W-1 -: OUT_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 out_q_o <= '0;
    else if (phase_q_i == PH_DUMP) out_q_o <= slice;
  end
endmodule

// File: rtl/acc_dump.sv
module acc_dump #(
  parameter int unsigned PROD_W  = 24,
  parameter int unsigned MAX_RUN = 256,
  parameter int unsigned OUT_LSB = PROD_W + $clog2(MAX_RUN) - 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic                     acc_i,
  output logic [15:0]              sum_o
);
  import acc_dump_pkg::*;

  localparam int unsigned GUARD_W = $clog2(MAX_RUN);
  localparam int unsigned SUM_W   = PROD_W + GUARD_W;

  logic signed [PROD_W-1:0] prod_q;
  acc_phase_e               phase_q;
  logic signed [SUM_W-1:0]  sum_q;
  logic [OUT_W-1:0]         out_q;

  acc_in_reg #(.PROD_W(PROD_W)) u_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prod_i    (prod_i),
    .acc_i     (acc_i),
    .prod_q_o  (prod_q),
    .phase_q_o (phase_q)
  );

  acc_sum #(.PROD_W(PROD_W), .SUM_W(SUM_W)) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prod_q_i  (prod_q),
    .phase_q_i (phase_q),
    .sum_q_o   (sum_q)
  );

  acc_dump_reg #(.SUM_W(SUM_W), .OUT_LSB(OUT_LSB)) u_dump (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sum_q_i   (sum_q),
    .phase_q_i (phase_q),
    .out_q_o   (out_q)
  );

  assign sum_o = out_q;
endmodule

// File: rtl/acc_dump_chk.sv
module acc_dump_chk #(
  parameter int unsigned PROD_W  = 24,
  parameter int unsigned SUM_W   = 32,
  parameter int unsigned OUT_LSB = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     acc_i,
  input logic signed [PROD_W-1:0] prod_i,
  input logic signed [PROD_W-1:0] prod_q,
  input logic                     phase_q,
  input logic signed [SUM_W-1:0]  sum_q,
  input logic [15:0]              sum_o
);
  logic signed [SUM_W-1:0] pext;
  assign pext = {{(SUM_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (sum_o == '0 && sum_q == '0 && !phase_q);
  end

  // R2
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |=> $stable(sum_o));

  // R2
  acc_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |=> sum_q == $past(sum_q) + $past(pext));

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_q |=> sum_q == $past(pext));

  // R4
  dump_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_q |=> sum_o == $past(sum_q[OUT_LSB +: 16]));

  // R5
  in_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_q == $past(acc_i)) && (prod_q == $past(prod_i)));
endmodule

bind acc_dump acc_dump_chk #(
  .PROD_W(PROD_W), .SUM_W(SUM_W), .OUT_LSB(OUT_LSB)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .acc_i   (acc_i),
  .prod_i  (prod_i),
  .prod_q  (prod_q),
  .phase_q (phase_q),
  .sum_q   (sum_q),
  .sum_o   (sum_o)
);

// File: tb/acc_dump_tb.sv
module acc_dump_tb;
  localparam int PW = 24;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic signed [PW-1:0] prod_i;
  logic               acc_i;
  logic [15:0]        sum_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic signed [31:0] win_sum;
  logic signed [31:0] last_win;

  acc_dump u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prod_i (prod_i),
    .acc_i  (acc_i),
    .sum_o  (sum_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [15:0] hi16(input logic signed [31:0] s);
    return s[31:16];
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (sum_o !== exp) begin
      errors++;
      $display("FAIL %s: sum_o=%h expected %h", req, sum_o, exp);
    end
  endtask

  // drive one sample, update reference window sums, return at next falling edge
  task automatic feed(input logic signed [PW-1:0] p, input bit a);
    prod_i = p;
    acc_i  = a;
    if (!a) begin
      last_win = win_sum;
      win_sum  = 32'(p);
    end else begin
      win_sum = win_sum + 32'(p);
    end
    @(negedge clk_i);
  endtask

  task automatic dump_check(input string req);
    logic signed [31:0] exp;
    feed('0, 1'b0);
    exp = last_win;
    feed('0, 1'b1);
    check(req, hi16(exp));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; prod_i = 24'sh7f0000; acc_i = 1'b1;
    win_sum = '0; last_win = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset", 16'h0000);
    acc_i = 1'b0; prod_i = '0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 after release", 16'h0000);
  endtask

  task automatic t_basic();
    feed(24'sh030000, 1'b0);
    feed(24'sh020000, 1'b1);
    feed(24'sh010000, 1'b1);
    feed(24'sh0a0000, 1'b0);   // closes window of 6, starts window at 10
    check("R5 no change after first edge", 16'h0000);
    feed(24'sh000000, 1'b1);
    check("R4 dump of 3+2+1", 16'h0006);
  endtask

  task automatic t_hold();
    // window started with 0x0a in t_basic; it must not include 6 (restart)
    for (int i = 0; i < 5; i++) begin
      feed(24'sh010000, 1'b1);
      check("R2 output holds in window", 16'h0006);
    end
    dump_check("R3 restart 10+0+5*1");
    checks++;
    if (last_win !== 32'sh000f0000) begin
      errors++;
      $display("FAIL R3: model sum=%h expected %h", last_win, 32'sh000f0000);
    end
  endtask

  task automatic t_single();
    logic signed [PW-1:0] ps [8];
    for (int i = 0; i < 8; i++) ps[i] = PW'((i + 1) * 32'sh11000 - 32'sh40000);
    for (int i = 0; i < 8; i++) begin
      feed(ps[i], 1'b0);
      if (i >= 2) check("R7 single-product window", hi16(32'(ps[i-2])));
    end
  endtask

  task automatic t_neg();
    feed(-24'sh050000, 1'b0);
    feed(24'sh020000, 1'b1);
    dump_check("R6 signed sum -3");
    check("R6 signed value", 16'hfffd);
  endtask

  task automatic t_extreme();
    feed(-24'sh800000, 1'b0);
    for (int i = 1; i < 256; i++) feed(-24'sh800000, 1'b1);
    dump_check("R6 256 x min");
    check("R6 min value", 16'h8000);
    feed(24'sh7fffff, 1'b0);
    for (int i = 1; i < 256; i++) feed(24'sh7fffff, 1'b1);
    dump_check("R6 256 x max");
    check("R6 max value", 16'h7fff);
  endtask

  task automatic t_random();
    for (int w = 0; w < 20; w++) begin
      int n = 1 + int'($urandom_range(23));
      feed(PW'($urandom), 1'b0);
      for (int k = 1; k < n; k++) feed(PW'($urandom), 1'b1);
      dump_check("R4 random window");
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_single();
    t_neg();
    t_extreme();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule